// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block gathers event interrupts from several subsystems and presents them to a host as one active-low request line. Each subsystem owns a group of sticky secondary status bits. An event pulse on the `evt_i` vector sets the bit it stands for, and each bit has its own mask. Every group folds its unmasked pending bits into one read-only primary status bit. Each primary bit has its own mask, which gates only the request line.

The host reaches all state through a flat register port. Writes take effect at the clock edge. Reads are combinational from the address. When the request line goes low, the host reads the primary status word to find the group that raised it, reads that group's secondary status, and clears the bits it has handled by writing 1 to them. The group count, group width, data width, address width and the bit position of each primary bit are parameters.

Top module: `irq_hub`

## Requirements
- R1: After reset every secondary status bit is 0, every secondary mask bit is 1, every implemented primary mask bit is 1 and `irq_n` is 1.
- R2: A 1 on `evt_i[g*SEC_W+b]` in a cycle sets secondary status bit b of group g at that clock edge. This also happens while the bit is masked, and the bit stays set until it is cleared.
- R3: Writing to the secondary status register of a group clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event and a clear write reach the same secondary bit in the same cycle, the bit ends up 1.
- R5: A primary status bit reads 1 exactly when its group has at least one secondary bit that is both set and unmasked. It returns to 0 once every set bit is cleared or masked. Unmasking a recorded bit sets the primary bit at once.
- R6: The primary status register is read-only. A write to address 0x00 changes no state.
- R7: The primary mask only gates the request line. A masked primary bit still reads its true value, and it keeps `irq_n` at 1.
- R8: In the default configuration, groups 0 to 6 drive primary bits 15, 14, 13, 12, 11, 8 and 7 respectively. Every other primary status bit and primary mask bit reads 0, and the implemented primary mask bits read back as 0xF980 after reset.
- R9: `irq_n` is a register. It is 0 while any primary bit is set with its mask bit clear, and 1 otherwise. It follows a change in status or mask one clock edge after that change becomes visible in the registers.
- R10: The address map is as follows. Address 0x00 holds the primary status and 0x01 the primary mask. Address 0x10+g holds the secondary status of group g and 0x20+g its secondary mask. Secondary data sits in bits [SEC_W-1:0], and the upper data bits read 0. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_GROUPS*SEC_W | Event pulses; bit g*SEC_W+b targets group g, bit b |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write enable for this cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_n | output | 1 | Registered interrupt request, active low |

## Verification
An event pulse and a write-1-to-clear can hit the same secondary bit in the same cycle. The bench provokes this by raising the event bit and issuing the clear write at the same falling edge. It then reads the group back, and only a value with the bit still set counts as correct. The same window is also probed the other way: the bench clears a bit on its own first, so a design that lets the clear win, or that ignores clears altogether, shows a value the bench does not expect. The checker also watches every secondary bit for this collision on each cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   // Register map anchors (word addresses)
   localparam int unsigned PRI_STAT_ADDR = 'h00;
   localparam int unsigned PRI_MASK_ADDR = 'h01;
   localparam int unsigned SEC_STAT_BASE = 'h10;
   localparam int unsigned SEC_MASK_BASE = 'h20;

   // A group index is carried in the low nibble of the address
   localparam int unsigned GRP_W      = 4;
   localparam int unsigned MAX_GROUPS = 1 << GRP_W;
   localparam int unsigned MIN_ADDR_W = 6;

   // Width of one entry of the primary position table
   localparam int unsigned POS_ENTRY_W = 8;

   typedef struct packed {
      logic             pri_stat;
      logic             pri_mask;
      logic             sec_stat;
      logic             sec_mask;
      logic [GRP_W-1:0] grp;
   } reg_sel_t;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 7,
   parameter int unsigned ADDR_W     = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   localparam int unsigned HI_W = ADDR_W - GRP_W;
   localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(PRI_STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_PMASK = ADDR_W'(PRI_MASK_ADDR);
   localparam logic [HI_W-1:0]   HI_SSTAT = HI_W'(SEC_STAT_BASE >> GRP_W);
   localparam logic [HI_W-1:0]   HI_SMASK = HI_W'(SEC_MASK_BASE >> GRP_W);

   logic [GRP_W-1:0] grp;
   logic [HI_W-1:0]  hi;
   logic             grp_ok;

   assign grp    = addr[GRP_W-1:0];
   assign hi     = addr[ADDR_W-1:GRP_W];
   assign grp_ok = ({1'b0, grp} < (GRP_W+1)'(NUM_GROUPS));

   always_comb begin
      sel          = '0;
      sel.grp      = grp;
      sel.pri_stat = (addr == A_PSTAT);
      sel.pri_mask = (addr == A_PMASK);
      sel.sec_stat = (hi == HI_SSTAT) && grp_ok;
      sel.sec_mask = (hi == HI_SMASK) && grp_ok;
   end

endmodule

// File: rtl/irq_hub_group.sv
module irq_hub_group #(
   parameter int unsigned SEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] evt,
   input  logic             stat_we,
   input  logic             mask_we,
   input  logic [SEC_W-1:0] wdata,
   output logic [SEC_W-1:0] stat,
   output logic [SEC_W-1:0] mask,
   output logic             pend
);

   logic [SEC_W-1:0] stat_q, mask_q;
   logic [SEC_W-1:0] clr, stat_nxt;

   // Clear first, then OR in new events: a same-cycle event survives.
   always_comb begin
      clr      = stat_we ? wdata : '0;
      stat_nxt = (stat_q & ~clr) | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= stat_nxt;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign stat = stat_q;
   assign mask = mask_q;
   assign pend = |(stat_q & ~mask_q);

endmodule

// File: rtl/irq_hub_primary.sv
module irq_hub_primary
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 7,
   parameter int unsigned DATA_W     = 16,
   parameter logic [NUM_GROUPS*POS_ENTRY_W-1:0] PRI_POS =
      {8'd7, 8'd8, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] grp_pend,
   input  logic                  mask_we,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     pri_stat,
   output logic [DATA_W-1:0]     pri_mask,
   output logic                  irq_n
);

   localparam int unsigned POS_W = $clog2(DATA_W);

   function automatic int unsigned pos_of(int unsigned g);
      return int'(PRI_POS[g*POS_ENTRY_W +: POS_ENTRY_W]);
   endfunction

   function automatic logic [DATA_W-1:0] valid_bits();
      logic [DATA_W-1:0] v;
      v = '0;
      for (int unsigned g = 0; g < NUM_GROUPS; g++)
         v[POS_W'(pos_of(g))] = 1'b1;
      return v;
   endfunction

   function automatic int unsigned count_valid();
      int unsigned n;
      logic [DATA_W-1:0] v;
      v = valid_bits();
      n = 0;
      for (int unsigned i = 0; i < DATA_W; i++) n += int'(v[i]);
      return n;
   endfunction

   localparam logic [DATA_W-1:0] VALID = valid_bits();

   // Elaboration checks on the position table
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pos_chk
      if (pos_of(g) >= DATA_W) begin : g_bad_pos
         $error("primary position of group %0d outside data word", g);
      end
   end
   if (count_valid() != NUM_GROUPS) begin : g_dup_pos
      $error("primary positions must be distinct");
   end
   if ((1 << POS_W) != DATA_W) begin : g_bad_dw
      $error("DATA_W must be a power of two");
   end

   // Primary status: each group's pending flag placed at its position
   logic [DATA_W-1:0] stat_c;
   always_comb begin
      stat_c = '0;
      for (int unsigned g = 0; g < NUM_GROUPS; g++)
         stat_c[POS_W'(pos_of(g))] = grp_pend[g];
   end

   logic [DATA_W-1:0] mask_q;
   logic              irq_n_q;
   logic              fire;

   assign fire = |(stat_c & ~mask_q & VALID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= VALID;
         irq_n_q <= 1'b1;
      end else begin
         if (mask_we) mask_q <= wdata & VALID;
         irq_n_q <= ~fire;
      end
   end

   assign pri_stat = stat_c;
   assign pri_mask = mask_q;
   assign irq_n    = irq_n_q;

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 7,
   parameter int unsigned SEC_W      = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 6,
   parameter logic [NUM_GROUPS*POS_ENTRY_W-1:0] PRI_POS =
      {8'd7, 8'd8, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15}
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_GROUPS*SEC_W-1:0] evt_i,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_we,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   output logic                        irq_n
);

   localparam int unsigned FLAT_W = NUM_GROUPS * SEC_W;

   // Elaboration checks
   if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_groups
      $error("NUM_GROUPS must lie in 1..%0d", MAX_GROUPS);
   end
   if (SEC_W < 1 || SEC_W > DATA_W) begin : g_bad_secw
      $error("SEC_W must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_aw
      $error("ADDR_W must be at least %0d", MIN_ADDR_W);
   end

   reg_sel_t sel;

   irq_hub_decode #(
      .NUM_GROUPS(NUM_GROUPS),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   logic [FLAT_W-1:0]     sec_stat_flat, sec_mask_flat;
   logic [NUM_GROUPS-1:0] grp_pend;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit, stat_we, mask_we;
      assign hit     = reg_we && (sel.grp == GRP_W'(g));
      assign stat_we = hit && sel.sec_stat;
      assign mask_we = hit && sel.sec_mask;

      irq_hub_group #(
         .SEC_W(SEC_W)
      ) u_grp (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_i[g*SEC_W +: SEC_W]),
         .stat_we(stat_we),
         .mask_we(mask_we),
         .wdata  (reg_wdata[SEC_W-1:0]),
         .stat   (sec_stat_flat[g*SEC_W +: SEC_W]),
         .mask   (sec_mask_flat[g*SEC_W +: SEC_W]),
         .pend   (grp_pend[g])
      );
   end

   logic [DATA_W-1:0] pri_stat, pri_mask;
   logic              pmask_we;

   assign pmask_we = reg_we && sel.pri_mask;

   irq_hub_primary #(
      .NUM_GROUPS(NUM_GROUPS),
      .DATA_W    (DATA_W),
      .PRI_POS   (PRI_POS)
   ) u_pri (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_pend(grp_pend),
      .mask_we (pmask_we),
      .wdata   (reg_wdata),
      .pri_stat(pri_stat),
      .pri_mask(pri_mask),
      .irq_n   (irq_n)
   );

   // Read mux
   always_comb begin
      reg_rdata = '0;
      if (sel.pri_stat) begin
         reg_rdata = pri_stat;
      end else if (sel.pri_mask) begin
         reg_rdata = pri_mask;
      end else begin
         for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
            if (sel.grp == GRP_W'(g)) begin
               if (sel.sec_stat) reg_rdata = DATA_W'(sec_stat_flat[g*SEC_W +: SEC_W]);
               if (sel.sec_mask) reg_rdata = DATA_W'(sec_mask_flat[g*SEC_W +: SEC_W]);
            end
         end
      end
   end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 7,
   parameter int unsigned SEC_W      = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 6,
   parameter logic [NUM_GROUPS*POS_ENTRY_W-1:0] PRI_POS =
      {8'd7, 8'd8, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15}
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_GROUPS*SEC_W-1:0] evt,
   input logic [NUM_GROUPS*SEC_W-1:0] sec_stat,
   input logic [NUM_GROUPS*SEC_W-1:0] sec_mask,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic                        reg_we,
   input logic [DATA_W-1:0]           reg_wdata,
   input logic [DATA_W-1:0]           pri_stat,
   input logic [DATA_W-1:0]           pri_mask,
   input logic                        irq_n
);

   logic [DATA_W-1:0] pos_map;
   logic              want_irq;

   always_comb begin
      pos_map = '0;
      for (int unsigned g = 0; g < NUM_GROUPS; g++)
         pos_map[int'(PRI_POS[g*POS_ENTRY_W +: POS_ENTRY_W])] = 1'b1;
   end

   assign want_irq = |(pri_stat & ~pri_mask);

   assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      want_irq |=> !irq_n);
   assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !want_irq |=> irq_n);
   assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pri_stat | pri_mask) & ~pos_map) == '0);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int unsigned P = int'(PRI_POS[g*POS_ENTRY_W +: POS_ENTRY_W]);
      logic pend;
      assign pend = |(sec_stat[g*SEC_W +: SEC_W] & ~sec_mask[g*SEC_W +: SEC_W]);

      assert_pri_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
         pri_stat[P] == pend);

      for (genvar b = 0; b < SEC_W; b++) begin : g_bit
         localparam int unsigned I = g*SEC_W + b;
         logic clr;
         assign clr = reg_we && (reg_addr == ADDR_W'(SEC_STAT_BASE + g)) && reg_wdata[b];

         assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[I] |=> sec_stat[I]);
         assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!sec_stat[I] && !evt[I]) |=> !sec_stat[I]);
         assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_stat[I] && !clr) |=> sec_stat[I]);
         assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[I]) |=> !sec_stat[I]);
         assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && evt[I]) |=> sec_stat[I]);
      end
   end

endmodule

bind irq_hub irq_hub_chk #(
   .NUM_GROUPS(NUM_GROUPS),
   .SEC_W     (SEC_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .PRI_POS   (PRI_POS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt      (evt_i),
   .sec_stat (sec_stat_flat),
   .sec_mask (sec_mask_flat),
   .reg_addr (reg_addr),
   .reg_we   (reg_we),
   .reg_wdata(reg_wdata),
   .pri_stat (pri_stat),
   .pri_mask (pri_mask),
   .irq_n    (irq_n)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
   localparam int NG = 7, SW = 8, DW = 16, AW = 6;
   localparam logic [AW-1:0] A_PS = 6'h00, A_PM = 6'h01, A_SS = 6'h10, A_SM = 6'h20;
   localparam logic [DW-1:0] VALID = 16'hF980;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NG*SW-1:0] evt = '0;
   logic [AW-1:0] addr = '0;
   logic we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic irq_n;

   always #4 clk = ~clk;

   irq_hub u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr), .reg_we(we),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [SW-1:0] m_stat [NG];
   logic [SW-1:0] m_smask[NG];
   logic [DW-1:0] m_pmask;
   int pos[NG] = '{15, 14, 13, 12, 11, 8, 7};

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_pri();
      logic [DW-1:0] p = '0;
      for (int g = 0; g < NG; g++)
         if ((m_stat[g] & ~m_smask[g]) != '0) p[pos[g]] = 1'b1;
      return p;
   endfunction

   function automatic logic exp_irq();
      return ~|(exp_pri() & ~m_pmask);
   endfunction

   function automatic logic [DW-1:0] exp_reg(logic [AW-1:0] a);
      if (a == A_PS) return exp_pri();
      if (a == A_PM) return m_pmask;
      if (a >= A_SS && a < A_SS + NG) return DW'(m_stat[a - A_SS]);
      if (a >= A_SM && a < A_SM + NG) return DW'(m_smask[a - A_SM]);
      return '0;
   endfunction

   task automatic rchk(string req, logic [AW-1:0] a);
      addr = a;
      #1;
      chk(req, $sformatf("read @%h", a), rdata, exp_reg(a));
   endtask

   // Write at the next edge, update the model accordingly
   task automatic mwr(logic [AW-1:0] a, logic [DW-1:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; wdata = '0;
      if (a == A_PM) m_pmask = d & VALID;
      else if (a >= A_SS && a < A_SS + NG) m_stat[a - A_SS] &= ~d[SW-1:0];
      else if (a >= A_SM && a < A_SM + NG) m_smask[a - A_SM] = d[SW-1:0];
   endtask

   task automatic pulse(int g, int b);
      evt[g*SW + b] = 1'b1;
      @(negedge clk);
      evt[g*SW + b] = 1'b0;
      m_stat[g][b] = 1'b1;
   endtask

   // irq_n must still hold its old value now and take the new one one edge later
   task automatic irq_lat(string req, logic old_irq);
      chk(req, "irq_n before update", DW'(irq_n), DW'(old_irq));
      @(negedge clk);
      chk(req, "irq_n after update", DW'(irq_n), DW'(exp_irq()));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic old;
      for (int g = 0; g < NG; g++) begin m_stat[g] = '0; m_smask[g] = '1; end
      m_pmask = VALID;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R8, R10: sweep every address at reset
      chk("R1", "irq_n at reset", DW'(irq_n), DW'(1'b1));
      for (int a = 0; a < 64; a++) rchk(a == 1 ? "R8" : "R1/R10", AW'(a));

      // R2: events recorded while masked; primary stays 0
      for (int g = 0; g < NG; g++)
         for (int b = 0; b < SW; b++) begin
            pulse(g, b);
            rchk("R2", A_SS + AW'(g));
            rchk("R5", A_PS);
         end
      chk("R7", "irq_n with all masked", DW'(irq_n), DW'(1'b1));

      // R3: writing zeros changes nothing; R10 unused address write ignored
      for (int g = 0; g < NG; g++) begin
         mwr(A_SS + AW'(g), '0);
         rchk("R3", A_SS + AW'(g));
      end
      mwr(6'h3F, 16'hFFFF);
      for (int a = 0; a < 64; a++) rchk("R10", AW'(a));

      // R5/R8: unmask one secondary bit at a time
      for (int g = 0; g < NG; g++) begin
         for (int b = 0; b < SW; b++) begin
            mwr(A_SM + AW'(g), DW'(~(8'h01 << b)));
            rchk("R5", A_PS);
            chk("R7", "irq_n with primary masked", DW'(irq_n), DW'(1'b1));
         end
         mwr(A_SM + AW'(g), 16'h00FF);
         rchk("R5", A_PS);
      end

      // R9/R7: primary mask gates irq only, with one cycle of latency
      for (int g = 0; g < NG; g++) begin
         mwr(A_SM + AW'(g), '0);
         old = exp_irq();
         mwr(A_PM, ~(16'h1 << pos[g]));
         irq_lat("R9", old);
         rchk("R8", A_PS);
         old = exp_irq();
         mwr(A_PM, 16'hFFFF);
         irq_lat("R9", old);
         rchk("R7", A_PS);
         mwr(A_SM + AW'(g), 16'h00FF);
      end

      // R5/R9: clear group 2 bit by bit; primary falls only after the last
      mwr(A_SM + 6'd2, '0);
      mwr(A_PM, ~(16'h1 << 13));
      @(negedge clk);
      chk("R9", "irq_n low with pending", DW'(irq_n), DW'(1'b0));
      for (int b = 0; b < SW; b++) begin
         old = exp_irq();
         mwr(A_SS + 6'd2, DW'(8'h01 << b));
         rchk("R5", A_PS);
         rchk("R3", A_SS + 6'd2);
         irq_lat("R9", old);
      end

      // R9: event path latency (group 4, primary bit 11)
      mwr(A_SS + 6'd4, 16'h00FF);
      mwr(A_SM + 6'd4, 16'h00FE);
      mwr(A_PM, ~(16'h1 << 11));
      @(negedge clk);
      old = exp_irq();
      pulse(4, 3);
      chk("R9", "irq_n after masked event", DW'(irq_n), DW'(old));
      pulse(4, 0);
      rchk("R5", A_PS);
      irq_lat("R9", old);

      // R6: primary status is read-only
      mwr(A_SM + 6'd0, '0);
      mwr(A_PS, 16'h0000);
      rchk("R6", A_PS);
      mwr(A_PS, 16'hFFFF);
      rchk("R6", A_PS);
      for (int a = 0; a < 64; a++) rchk("R6", AW'(a));

      // R4: clear alone, then clear colliding with an event
      mwr(A_SS + 6'd3, 16'h0020);
      rchk("R3", A_SS + 6'd3);
      addr = A_SS + 6'd3; wdata = 16'h0060; we = 1'b1; evt[3*SW + 5] = 1'b1;
      @(negedge clk);
      we = 1'b0; wdata = '0; evt[3*SW + 5] = 1'b0;
      m_stat[3][6] = 1'b0; m_stat[3][5] = 1'b1;
      rchk("R4", A_SS + 6'd3);
      chk("R4", "set-wins bit", DW'(rdata[5]), DW'(1'b1));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule